// File: doc/BRIEF.md
# Constant-Key GHASH Accumulator

This block keeps the running authentication value of a Galois/Counter Mode message when the hash subkey is fixed at build time. Elaboration turns the subkey, given as a parameter, into a table of 128 rows of 128 bits. Row i holds the subkey after i steps of shift-and-reduce. A full field product is then the XOR of the rows picked out by the set bits of the operand. That is pure combinational logic, and only the 1-bits of the table turn into XOR gates.

Each cycle with `blk_valid_i` high takes in one 128-bit block C and replaces the running value X with (X xor C)·H. The result feeds straight back, so the block can take one new data block on every clock. `restart_i` begins a new message. A two-state controller tracks whether the accumulator is empty or holds a partial hash. The caller formats the length block and XORs the final tag with the encrypted counter block outside this unit.

Top module: `ghash_fixed_h`

## Requirements
- R1: After reset, `tag_o` is all zeros, `live_o` is 0 and the controller is in state EMPTY.
- R2: Bit ordering follows GCM: operand bit k (k = 0 is `blk_i[127]`, the MSB) selects the table row equal to H after k steps. A block with only bit 0 set, taken into an empty accumulator, gives `tag_o` = H.
- R3: The product equals the bit-serial GF(2^128) multiply with reduction constant 0xE1 followed by 120 zero bits. In each serial step V moves one place toward the LSB, and the constant is XORed in when the bit falling off (`V[0]`) was 1.
- R4: When `blk_valid_i` is high and `restart_i` is low, `tag_o` equals (old `tag_o` xor `blk_i`)·H after the next rising edge.
- R5: When both `blk_valid_i` and `restart_i` are low, `tag_o` and `live_o` keep their values.
- R6: When `restart_i` is high and `blk_valid_i` is low, `tag_o` becomes zero and `live_o` becomes 0 on the next edge (transition DRAIN: ABSORB→EMPTY).
- R7: When `restart_i` and `blk_valid_i` are both high, the old value is discarded and `tag_o` becomes `blk_i`·H. This starts a new message in the same cycle.
- R8: Blocks offered on consecutive cycles are each taken in, with no idle cycle between them.
- R9: `live_o` goes to 1 on the edge that takes in a block (transition FILL: EMPTY→ABSORB) and stays 1 until a restart without a block. In state EMPTY, `tag_o` is zero.
- R10: Taking in a block equal to the current `tag_o` (without restart) drives `tag_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_valid_i | input | 1 | `blk_i` carries a block to take in this cycle |
| blk_i | input | 128 | Data block, GCM bit order (bit 0 = MSB) |
| restart_i | input | 1 | Start a new message (clears the running value) |
| tag_o | output | 128 | Running GHASH value X |
| live_o | output | 1 | High while X holds at least one block of the current message |

## Verification
Every one-hot operand, from bit 0 to bit 127, is multiplied into an empty accumulator and compared with a bit-serial multiply written in the bench. This separates each table row and catches any reversal of bit order or shift direction. Random dense operands check that the rows combine correctly under XOR. Back-to-back chains of random blocks check the feedback path and full throughput. Idle cycles, restarts with and without a block, and a block equal to the tag tell apart the hold, clear, new-message and zero-product behaviour.

// File: rtl/ghfx_pkg.sv
package ghfx_pkg;
    localparam int BLK_W = 128;
    typedef logic [BLK_W-1:0] blk_t;
    typedef enum logic {ST_EMPTY, ST_ABSORB} acc_state_e;

    // one shift-and-reduce step in GCM bit order (index 0 = MSB)
    function automatic blk_t gf_step(blk_t v, blk_t poly);
        return v[0] ? ((v >> 1) ^ poly) : (v >> 1);
    endfunction

    // row idx of the specialised table: h after idx steps
    function automatic blk_t tbl_row(blk_t h, blk_t poly, int idx);
        blk_t v;
        v = h;
        for (int k = 0; k < idx; k++) v = gf_step(v, poly);
        return v;
    endfunction
endpackage

// File: rtl/ghfx_table.sv
module ghfx_table
    import ghfx_pkg::*;
#(
    parameter blk_t H_KEY = 128'hc6a13b37878f5b826f4f8162a1c8d879,
    parameter blk_t POLY  = {8'he1, 120'd0}
) (
    output logic [BLK_W-1:0][BLK_W-1:0] rows_o
);
    for (genvar i = 0; i < BLK_W; i++) begin : g_row
        localparam blk_t ROW = tbl_row(H_KEY, POLY, i);
        assign rows_o[i] = ROW;
    end
endmodule

// File: rtl/ghfx_mul.sv
module ghfx_mul
    import ghfx_pkg::*;
(
    input  blk_t                        opnd_i,
    input  logic [BLK_W-1:0][BLK_W-1:0] rows_i,
    output blk_t                        prod_o
);
    always_comb begin
        prod_o = '0;
        for (int i = 0; i < BLK_W; i++) begin
            // operand bit i in GCM order sits at vector index BLK_W-1-i
            prod_o = prod_o ^ (rows_i[i] & {BLK_W{opnd_i[BLK_W-1-i]}});
        end
    end
endmodule

// File: rtl/ghfx_ctrl.sv
module ghfx_ctrl
    import ghfx_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       valid_i,
    input  logic       restart_i,
    output acc_state_e state_o,
    output logic       load_o,
    output logic       zero_o,
    output logic       fresh_o
);
    acc_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_EMPTY;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (valid_i) state_d = ST_ABSORB;               // FILL
            ST_ABSORB: if (restart_i && !valid_i) state_d = ST_EMPTY;  // DRAIN
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        load_o  = valid_i;
        zero_o  = 1'b0;
        fresh_o = 1'b0;
        unique case (state_q)
            ST_EMPTY:  fresh_o = 1'b1;
            ST_ABSORB: begin
                fresh_o = restart_i;
                zero_o  = restart_i && !valid_i;
            end
            default:   fresh_o = 1'b1;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/ghash_fixed_h.sv
module ghash_fixed_h
    import ghfx_pkg::*;
#(
    parameter blk_t H_KEY = 128'hc6a13b37878f5b826f4f8162a1c8d879,
    parameter blk_t POLY  = {8'he1, 120'd0}
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           blk_valid_i,
    input  logic [127:0]   blk_i,
    input  logic           restart_i,
    output logic [127:0]   tag_o,
    output logic           live_o
);
    logic [BLK_W-1:0][BLK_W-1:0] rows;
    acc_state_e                  state;
    logic                        load, zero, fresh;
    blk_t                        tag_q, opnd, prod;

    ghfx_table #(.H_KEY(H_KEY), .POLY(POLY)) u_table (.rows_o(rows));

    ghfx_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .valid_i  (blk_valid_i),
        .restart_i(restart_i),
        .state_o  (state),
        .load_o   (load),
        .zero_o   (zero),
        .fresh_o  (fresh)
    );

    assign opnd = (fresh ? '0 : tag_q) ^ blk_i;

    ghfx_mul u_mul (.opnd_i(opnd), .rows_i(rows), .prod_o(prod));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   tag_q <= '0;
        else if (load) tag_q <= prod;
        else if (zero) tag_q <= '0;
    end

    assign tag_o  = tag_q;
    assign live_o = (state == ST_ABSORB);
endmodule

// File: rtl/ghfx_checker.sv
module ghfx_checker (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         blk_valid_i,
    input logic [127:0] blk_i,
    input logic         restart_i,
    input logic [127:0] tag_o,
    input logic         live_o
);
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!blk_valid_i && !restart_i) |=> ($stable(tag_o) && $stable(live_o)));

    p_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restart_i && !blk_valid_i) |=> (tag_o == '0 && !live_o));

    p_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk_valid_i |=> live_o);

    p_empty_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !live_o |-> (tag_o == '0));

    p_cancel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blk_valid_i && !restart_i && blk_i == tag_o) |=> (tag_o == '0));
endmodule

bind ghash_fixed_h ghfx_checker u_ghfx_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blk_valid_i(blk_valid_i),
    .blk_i      (blk_i),
    .restart_i  (restart_i),
    .tag_o      (tag_o),
    .live_o     (live_o)
);

// File: tb/test_ghash_fixed_h.sv
`timescale 1ns/1ps
module test_ghash_fixed_h;
    localparam logic [127:0] HK = 128'hc6a13b37878f5b826f4f8162a1c8d879;
    localparam logic [127:0] RP = {8'he1, 120'd0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld = 1'b0;
    logic         rst_msg = 1'b0;
    logic [127:0] blk = '0;
    logic [127:0] tag;
    logic         live;
    int           total = 0;
    int           bad = 0;
    logic [127:0] model;

    always #2.5 clk = ~clk;

    ghash_fixed_h #(.H_KEY(HK)) i_ghash_fixed_h (
        .clk_i(clk), .rst_ni(rst_n), .blk_valid_i(vld), .blk_i(blk),
        .restart_i(rst_msg), .tag_o(tag), .live_o(live)
    );

    // bit-serial reference: operand bit i (GCM order) is a[127-i]
    function automatic logic [127:0] ser_mul(logic [127:0] a, logic [127:0] h);
        logic [127:0] z, v;
        z = '0;
        v = h;
        for (int i = 0; i < 128; i++) begin
            if (a[127-i]) z ^= v;
            v = v[0] ? ((v >> 1) ^ RP) : (v >> 1);
        end
        return z;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic cyc(input logic v, input logic c, input logic [127:0] d);
        @(negedge clk);
        vld = v; rst_msg = c; blk = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [127:0] exp_tag, input logic exp_live);
        total++;
        if (tag !== exp_tag || live !== exp_live) begin
            bad++;
            $display("FAIL %s tag=%h live=%b expected tag=%h live=%b",
                     req, tag, live, exp_tag, exp_live);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", '0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after reset", '0, 1'b0);

        // R2: bit 0 (MSB) alone yields H
        cyc(1'b1, 1'b0, {1'b1, 127'd0});
        chk("R2 msb operand gives H", HK, 1'b1);

        // R2/R3: every one-hot operand, each started fresh with restart+valid (R7)
        for (int k = 0; k < 128; k++) begin
            logic [127:0] a;
            a = 128'd1 << (127 - k);
            cyc(1'b1, 1'b1, a);
            chk("R2 one-hot row", ser_mul(a, HK), 1'b1);
        end

        // R3/R7: dense random operands
        for (int n = 0; n < 40; n++) begin
            logic [127:0] a;
            a = rnd128();
            cyc(1'b1, 1'b1, a);
            chk("R3 R7 dense product", ser_mul(a, HK), 1'b1);
        end

        // R6: restart alone drains
        cyc(1'b0, 1'b1, rnd128());
        chk("R6 restart clears", '0, 1'b0);
        // R5: idle in empty state
        cyc(1'b0, 1'b0, rnd128());
        chk("R5 hold while empty", '0, 1'b0);

        // R4/R8/R9: back-to-back chains
        for (int m = 0; m < 6; m++) begin
            model = '0;
            cyc(1'b0, 1'b1, '0);
            chk("R9 empty before chain", '0, 1'b0);
            for (int j = 0; j < 12; j++) begin
                logic [127:0] d;
                d = rnd128();
                model = ser_mul(model ^ d, HK);
                cyc(1'b1, 1'b0, d);
                chk("R4 R8 chained absorb", model, 1'b1);
            end
            // R5: idle keeps the partial hash
            cyc(1'b0, 1'b0, rnd128());
            chk("R5 hold while absorbing", model, 1'b1);
            cyc(1'b0, 1'b0, rnd128());
            chk("R5 hold second cycle", model, 1'b1);
            // R7: restart with block discards history
            begin
                logic [127:0] d;
                d = rnd128();
                model = ser_mul(d, HK);
                cyc(1'b1, 1'b1, d);
                chk("R7 restart with block", model, 1'b1);
            end
        end

        // R10: block equal to tag cancels
        cyc(1'b1, 1'b0, tag);
        chk("R10 block equal to tag", '0, 1'b1);
        cyc(1'b1, 1'b0, '0);
        chk("R10 zero block on zero tag", '0, 1'b1);

        // R6: restart from absorbing state
        cyc(1'b1, 1'b0, 128'h1);
        cyc(1'b0, 1'b1, '0);
        chk("R6 drain from absorb", '0, 1'b0);

        cyc(1'b0, 1'b0, '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule